// File: doc/BRIEF.md
# Serial Clock Generator for a Multi-Select SPI Master

This block produces the serial clock of an SPI master that talks to several peripherals, each behind its own chip select and each with its own speed, idle polarity and sampling phase. A master tick is derived from the system clock, either on every cycle or once every 32 cycles. That tick is then divided by an even ratio 2·N, where N is the 8-bit divide field held for the currently selected chip select. The serial clock therefore spends N master ticks in each half period.

Beside the clock pin the block drives two one-cycle strobes for the shift register: `launch_o` tells it to put the next bit on the data line and `capture_o` tells it to sample the incoming bit. A transfer begins when `run_i` is high while the block is idle. At that edge the selected chip select's settings and the prescale choice are frozen for the whole transfer. Dropping `run_i` ends the transfer at the next half-period boundary, and the clock is then back at its idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is held, `sclk_o`, `active_o`, `launch_o` and `capture_o` are all 0.
- R2: With `pre32_i` = 0 at start, each half period of `sclk_o` lasts N system cycles. With `pre32_i` = 1 it lasts 32·N cycles. The first toggle comes that many cycles after the start edge.
- R3: N is taken from byte `div_field_i[8*k +: 8]` of the chip select k given by `cs_sel_i` at start, so each chip select runs at its own rate.
- R4: A divide field of 0 or 1 acts as N = 2.
- R5: While idle, `sclk_o` follows `cpol_i[cs_sel_i]` one cycle later.
- R6: With phase bit `cpha_i[k]` = 0, `launch_o` pulses in the cycle after the start edge and on every trailing edge of a continuing transfer, and `capture_o` pulses on every leading edge. The leading edge is the toggle away from the idle level.
- R7: With `cpha_i[k]` = 1, `launch_o` pulses on every leading edge and `capture_o` on every trailing edge.
- R8: Changes to `cs_sel_i`, `div_field_i`, `cpol_i`, `cpha_i` or `pre32_i` while `active_o` is high have no effect on `sclk_o` or on the strobes.
- R9: When `run_i` is low at a half-period boundary, the transfer ends there and `sclk_o` is at the idle level. A pending leading edge is suppressed. A pending trailing edge still occurs, and it still carries a capture strobe when the phase bit is 1.
- R10: `launch_o` and `capture_o` are each one system cycle wide and are never high together.
- R11: `active_o` rises in the cycle after `run_i` is seen high while idle, and falls after the half period in which `run_i` was seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre32_i | input | 1 | 1 selects the system clock divided by 32 as the master tick |
| cs_sel_i | input | CS_W | Index of the active chip select |
| div_field_i | input | NUM_CS*8 | Per-select divide field N, byte k for chip select k |
| cpol_i | input | NUM_CS | Per-select idle level of the serial clock |
| cpha_i | input | NUM_CS | Per-select phase bit |
| run_i | input | 1 | Start a transfer / keep it running |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe: shift out the next bit |
| capture_o | output | 1 | One-cycle strobe: sample the incoming bit |
| active_o | output | 1 | High while a transfer is in progress |

## Verification
The generator is driven with four chip-select profiles that differ in divide field, polarity and phase. One profile uses a field of 0 to exercise the clamp, and one runs behind the /32 prescale. This separates errors in the half-period length from errors in edge direction and strobe choice. Mid-transfer rewrites of every configuration input show whether the settings are really frozen at start. A sweep of stop points over consecutive cycles lands the stop request in both the leading and the trailing half. This tells the suppressed edge apart from the completed one, and shows whether a stop drops the capture strobe.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    parameter int unsigned SCLK_FIELD_W = 8;

    typedef struct packed {
        logic [SCLK_FIELD_W-1:0] half;   // master ticks per half period
        logic                    cpol;
        logic                    cpha;
        logic                    pre32;
    } cs_cfg_t;

    typedef struct packed {
        logic    active;
        logic    sclk;
        logic    launch;
        logic    capture;
        cs_cfg_t cfg;
    } gen_state_t;

endpackage

// File: rtl/spi_cfg_select.sv
module spi_cfg_select
    import spi_sclk_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [CS_W-1:0]              sel_i,
    input  logic [NUM_CS*SCLK_FIELD_W-1:0] field_i,
    input  logic [NUM_CS-1:0]            cpol_i,
    input  logic [NUM_CS-1:0]            cpha_i,
    input  logic                         pre32_i,
    output cs_cfg_t                      cfg_o
);
    localparam logic [SCLK_FIELD_W-1:0] MIN_HALF = SCLK_FIELD_W'(2);

    logic [SCLK_FIELD_W-1:0] half_arr [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        always_comb begin
            half_arr[k] = field_i[k*SCLK_FIELD_W +: SCLK_FIELD_W];
            if (half_arr[k] < MIN_HALF) begin
                half_arr[k] = MIN_HALF;
            end
        end
    end

    always_comb begin
        cfg_o       = '0;
        cfg_o.pre32 = pre32_i;
        if (int'(sel_i) < NUM_CS) begin
            cfg_o.half = half_arr[sel_i];
            cfg_o.cpol = cpol_i[sel_i];
            cfg_o.cpha = cpha_i[sel_i];
        end else begin
            cfg_o.half = MIN_HALF;
        end
    end

endmodule

// File: rtl/spi_mclk_prescale.sv
module spi_mclk_prescale #(
    parameter int unsigned PRE_DIV = 32,
    localparam int unsigned PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (slow_i) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
        tick_o = !clr_i && (!slow_i || wrap);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
    import spi_sclk_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    tick_i,
    input  logic [SCLK_FIELD_W-1:0] half_i,
    output logic                    end_o
);
    logic [SCLK_FIELD_W-1:0] cnt_d, cnt_q;
    logic                    last;

    always_comb begin
        last  = (cnt_q == half_i - 1'b1);
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
        end_o = !clr_i && tick_i && last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int unsigned NUM_CS  = 4,
    parameter int unsigned PRE_DIV = 32,
    parameter int unsigned CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           pre32_i,
    input  logic [CS_W-1:0]                cs_sel_i,
    input  logic [NUM_CS*SCLK_FIELD_W-1:0] div_field_i,
    input  logic [NUM_CS-1:0]              cpol_i,
    input  logic [NUM_CS-1:0]              cpha_i,
    input  logic                           run_i,
    output logic                           sclk_o,
    output logic                           launch_o,
    output logic                           capture_o,
    output logic                           active_o
);
    gen_state_t st_d, st_q;
    cs_cfg_t    sel_cfg;
    cs_cfg_t    cfg_live;
    logic       mtick;
    logic       half_end;
    logic       lead;

    spi_cfg_select #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_sel (
        .sel_i   (cs_sel_i),
        .field_i (div_field_i),
        .cpol_i  (cpol_i),
        .cpha_i  (cpha_i),
        .pre32_i (pre32_i),
        .cfg_o   (sel_cfg)
    );

    spi_mclk_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!st_q.active),
        .slow_i (st_q.cfg.pre32),
        .tick_o (mtick)
    );

    spi_half_timer i_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (!st_q.active),
        .tick_i (mtick),
        .half_i (st_q.cfg.half),
        .end_o  (half_end)
    );

    always_comb begin
        st_d         = st_q;
        st_d.launch  = 1'b0;
        st_d.capture = 1'b0;
        lead         = (st_q.sclk == st_q.cfg.cpol);
        if (!st_q.active) begin
            st_d.sclk = sel_cfg.cpol;
            if (run_i) begin
                st_d.active = 1'b1;
                st_d.cfg    = sel_cfg;
                st_d.launch = !sel_cfg.cpha;
            end
        end else if (half_end) begin
            if (!run_i) begin
                st_d.active  = 1'b0;
                st_d.sclk    = st_q.cfg.cpol;
                st_d.capture = !lead && st_q.cfg.cpha;
            end else begin
                st_d.sclk    = !st_q.sclk;
                st_d.launch  = (lead == st_q.cfg.cpha);
                st_d.capture = (lead != st_q.cfg.cpha);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_live  = st_q.cfg;
    assign sclk_o    = st_q.sclk;
    assign launch_o  = st_q.launch;
    assign capture_o = st_q.capture;
    assign active_o  = st_q.active;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk
    import spi_sclk_pkg::*;
(
    input logic    clk_i,
    input logic    rst_ni,
    input logic    active_i,
    input logic    sclk_i,
    input logic    launch_i,
    input logic    capture_i,
    input cs_cfg_t cfg_i
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(launch_i && capture_i));

    // R6
    capture_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |-> (sclk_i != $past(sclk_i)));

    // R7
    launch_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (launch_i && $past(active_i)) |-> (sclk_i != $past(sclk_i)));

    // R9
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(active_i) |-> (sclk_i == cfg_i.cpol));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && $past(active_i)) |-> $stable(cfg_i));

    // R4
    half_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> (cfg_i.half >= SCLK_FIELD_W'(2)));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active_o),
    .sclk_i    (sclk_o),
    .launch_i  (launch_o),
    .capture_i (capture_o),
    .cfg_i     (cfg_live)
);

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;
    localparam int NCS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pre32 = 1'b0;
    logic [1:0]     sel = '0;
    logic [NCS*8-1:0] fields = '0;
    logic [NCS-1:0] cpol = '0;
    logic [NCS-1:0] cpha = '0;
    logic           run = 1'b0;
    logic           sclk, launch, capture, active;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    bit m_act, m_sclk, m_l, m_c, m_cpol, m_cpha;
    int m_rem, m_len;

    always #10 clk = ~clk;

    spi_sclk_gen i_spi_sclk_gen (
        .clk_i(clk), .rst_ni(rst_n), .pre32_i(pre32), .cs_sel_i(sel),
        .div_field_i(fields), .cpol_i(cpol), .cpha_i(cpha), .run_i(run),
        .sclk_o(sclk), .launch_o(launch), .capture_o(capture), .active_o(active)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_sclk = 0; m_l = 0; m_c = 0;
        end else begin
            m_l = 0; m_c = 0;
            if (!m_act) begin
                m_sclk = cpol[sel];
                if (run) begin
                    int n;
                    n = int'(fields[sel*8 +: 8]);
                    if (n < 2) n = 2;
                    m_len  = n * (pre32 ? 32 : 1);
                    m_rem  = m_len;
                    m_act  = 1;
                    m_cpol = cpol[sel];
                    m_cpha = cpha[sel];
                    m_l    = !m_cpha;
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    bit ld;
                    m_rem = m_len;
                    ld = (m_sclk == m_cpol);
                    if (!run) begin
                        m_act = 0;
                        if (!ld) begin
                            m_sclk = m_cpol;
                            m_c    = m_cpha;
                        end
                    end else begin
                        m_sclk = !m_sclk;
                        if (ld) begin m_l = m_cpha;  m_c = !m_cpha; end
                        else    begin m_l = !m_cpha; m_c = m_cpha;  end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if ({sclk, launch, capture, active} != {m_sclk, m_l, m_c, m_act}) begin
                errors++;
                $display("FAIL %s sclk/launch/capture/active actual %b%b%b%b expected %b%b%b%b",
                         cur_req, sclk, launch, capture, active, m_sclk, m_l, m_c, m_act);
            end
            // R10: strobes never overlap
            checks++;
            if (launch && capture) begin
                errors++;
                $display("FAIL R10 launch=%b capture=%b expected not both", launch, capture);
            end
        end
    end

    task automatic wait_idle();
        run = 1'b0;
        for (int i = 0; i < 20000 && m_act; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic burst(input int cs, input bit p, input int cyc);
        sel = 2'(cs); pre32 = p; run = 1'b1;
        repeat (cyc) @(negedge clk);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // cs0: N=2 pol0 ph0, cs1: N=5 pol1 ph1, cs2: N=0 pol0 ph1, cs3: N=3 pol1 ph0
        fields = {8'd3, 8'd0, 8'd5, 8'd2};
        cpol = 4'b1010;
        cpha = 4'b0110;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({sclk, launch, capture, active} != 4'b0000) begin
            errors++;
            $display("FAIL R1 actual %b%b%b%b expected 0000", sclk, launch, capture, active);
        end
        rst_n = 1'b1;
        cur_req = "R5";
        for (int k = 0; k < NCS; k++) begin
            sel = 2'(k);
            repeat (3) @(negedge clk);
        end
        cur_req = "R6"; burst(0, 0, 41);
        cur_req = "R7"; burst(1, 0, 63);
        cur_req = "R4"; burst(2, 0, 30);
        fields[2*8 +: 8] = 8'd1;
        burst(2, 0, 17);
        cur_req = "R2"; burst(3, 1, 700);
        cur_req = "R3"; burst(3, 0, 40);
        burst(1, 0, 40);
        cur_req = "R8";
        sel = 2'd1; pre32 = 1'b0; run = 1'b1;
        repeat (7) @(negedge clk);
        sel = 2'd0; pre32 = 1'b1; fields[1*8 +: 8] = 8'd9;
        cpol = ~cpol; cpha = ~cpha;
        repeat (80) @(negedge clk);
        wait_idle();
        fields = {8'd3, 8'd0, 8'd5, 8'd2};
        cpol = 4'b1010;
        cpha = 4'b0110;
        cur_req = "R9";
        for (int k = 0; k < 12; k++) begin
            burst(1, 0, k + 1);
            burst(3, 0, k + 1);
        end
        cur_req = "R11";
        for (int k = 0; k < 6; k++) burst(0, 0, k + 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule